// File: doc/BRIEF.md
# Privilege-Checked Virtual Address Segment Decoder

This block takes one 32-bit virtual address per cycle and sorts it into one of five fixed segments. The top bits of the address pick the segment. Whether the access is allowed depends on the current privilege mode and on an error-level flag. Two kernel windows are unmapped and are translated by subtracting their base. The user window is passed through unchanged while the error-level flag is set. All other allowed accesses go out on a lookup port to an external translation buffer, and the reply from that buffer comes back in the same cycle.

The result is registered and appears one cycle after the request. It carries the physical address and read/write permission, or a fault with a 5-bit exception cause. When a fault occurs, the block also outputs new values for three fault registers: the faulting address, a context word and an entry-high word. The caller supplies the current context and entry-high values so that the bits that must be kept can be merged in.

Top module: `seg_xlate`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, out_valid, fault, exc_code, refill, phys_addr, both permissions, bad_vaddr, ctx_out and ehi_out are all zero.
- R2: An address with bit 31 clear and err_lvl high translates to itself with read and write permission, in every mode. No lookup is issued and the translation-buffer reply is ignored.
- R3: An address with bits 31:29 = 100 in mode 0 (kernel) translates to the address minus 0x80000000, with read and write permission.
- R4: An address with bits 31:29 = 101 in mode 0 translates to the address minus 0xA0000000, with read and write permission.
- R5: tlb_lookup is high, with tlb_vaddr equal to req_addr, in exactly these cases: bit 31 clear with err_lvl low (any mode); bits 31:29 = 110 in mode 0 or 1; bits 31:29 = 111 in mode 0. A hit whose valid bit is set and whose access is allowed gives phys_addr = tlb_paddr, perm_read = 1 and perm_write = tlb_dirty.
- R6: Mode 0 is kernel, 1 is supervisor, and 2 or 3 is user. A kernel-only window accessed outside mode 0, or the 110 window accessed in user mode, faults with cause 4 for a read or 5 for a write, with refill 0 and no lookup.
- R7: A lookup that misses faults with cause 2 for a read or 3 for a write, with refill = 1.
- R8: A lookup that hits an entry whose valid bit is clear faults with cause 2 or 3 (read or write), with refill = 0.
- R9: A write that hits a valid entry whose dirty bit is clear faults with cause 1. A read of the same entry succeeds with read-only permission.
- R10: On a fault, phys_addr and both permissions are zero, and the fault registers load as follows. bad_vaddr = address. ctx_out = {ctx_in[31:23], addr[31:13], 4'b0}. ehi_out = {addr[31:13], 5'b0, ehi_in[7:0]}.
- R11: Each result appears on the cycle after its request, with out_valid equal to the previous req_valid. Without a fault, or without a request, bad_vaddr, ctx_out and ehi_out keep their values, and fault, exc_code and refill are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | Privilege: 0 kernel, 1 supervisor, 2/3 user |
| err_lvl | input | 1 | Error-level flag; bypasses translation in the user window |
| ctx_in | input | 32 | Current context word, upper bits kept on fault |
| ehi_in | input | 32 | Current entry-high word, low byte kept on fault |
| tlb_lookup | output | 1 | Lookup request to the translation buffer |
| tlb_vaddr | output | 32 | Address presented for lookup |
| tlb_hit | input | 1 | Translation buffer matched |
| tlb_valid | input | 1 | Matched half-page is valid |
| tlb_dirty | input | 1 | Matched half-page is writable |
| tlb_paddr | input | 32 | Translated physical address |
| out_valid | output | 1 | Registered result is present |
| phys_addr | output | 32 | Physical address |
| perm_read | output | 1 | Read permitted |
| perm_write | output | 1 | Write permitted |
| fault | output | 1 | Access faulted |
| exc_code | output | 5 | Exception cause (0 when no fault) |
| refill | output | 1 | Fault was a lookup miss |
| bad_vaddr | output | 32 | Faulting address |
| ctx_out | output | 32 | Updated context word |
| ehi_out | output | 32 | Updated entry-high word |

## Verification
Two pairs of decisions can fall in the same cycle, and in each pair one result must win. First, when the error-level bypass and a translation-buffer reply coincide, the bypass wins. Second, when a privilege check and a translation-buffer reply coincide, the privilege check wins. The sweep drives every combination of segment, mode, error level, direction and hit/valid/dirty reply together, so misses and read-only replies are present while a bypass or privilege error is taken. Each outcome is judged against a bench model of the segment rules. The lookup strobe is also checked within the cycle, to confirm that the shadowed reply was never requested.

// File: rtl/seg_xlate.sv
module seg_xlate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic [1:0]  req_mode,
  input  logic        err_lvl,
  input  logic [31:0] ctx_in,
  input  logic [31:0] ehi_in,
  output logic        tlb_lookup,
  output logic [31:0] tlb_vaddr,
  input  logic        tlb_hit,
  input  logic        tlb_valid,
  input  logic        tlb_dirty,
  input  logic [31:0] tlb_paddr,
  output logic        out_valid,
  output logic [31:0] phys_addr,
  output logic        perm_read,
  output logic        perm_write,
  output logic        fault,
  output logic [4:0]  exc_code,
  output logic        refill,
  output logic [31:0] bad_vaddr,
  output logic [31:0] ctx_out,
  output logic [31:0] ehi_out
);
  localparam logic [4:0] C_MOD  = 5'd1;
  localparam logic [4:0] C_TLBL = 5'd2;
  localparam logic [4:0] C_TLBS = 5'd3;
  localparam logic [4:0] C_ADEL = 5'd4;
  localparam logic [4:0] C_ADES = 5'd5;

  logic kern, sup;
  assign kern = (req_mode == 2'd0);
  assign sup  = (req_mode == 2'd1);

  logic        want_map, priv_bad, n_fault, n_refill, n_rd, n_wr;
  logic [4:0]  n_code;
  logic [31:0] n_phys;

  always_comb begin
    want_map = 1'b0;
    priv_bad = 1'b0;
    n_phys   = '0;
    n_rd     = 1'b0;
    n_wr     = 1'b0;
    n_fault  = 1'b0;
    n_code   = '0;
    n_refill = 1'b0;
    case (req_addr[31:29])
      3'b100, 3'b101:
        if (kern) begin
          n_phys = {3'b000, req_addr[28:0]};
          n_rd = 1'b1; n_wr = 1'b1;
        end else priv_bad = 1'b1;
      3'b110:
        if (kern || sup) want_map = 1'b1;
        else priv_bad = 1'b1;
      3'b111:
        if (kern) want_map = 1'b1;
        else priv_bad = 1'b1;
      default:
        if (err_lvl) begin
          n_phys = req_addr;
          n_rd = 1'b1; n_wr = 1'b1;
        end else want_map = 1'b1;
    endcase
    if (priv_bad) begin
      n_fault = 1'b1;
      n_code  = req_write ? C_ADES : C_ADEL;
    end else if (want_map) begin
      if (!tlb_hit) begin
        n_fault = 1'b1; n_refill = 1'b1;
        n_code  = req_write ? C_TLBS : C_TLBL;
      end else if (!tlb_valid) begin
        n_fault = 1'b1;
        n_code  = req_write ? C_TLBS : C_TLBL;
      end else if (req_write && !tlb_dirty) begin
        n_fault = 1'b1;
        n_code  = C_MOD;
      end else begin
        n_phys = tlb_paddr;
        n_rd   = 1'b1;
        n_wr   = tlb_dirty;
      end
    end
    if (n_fault) begin
      n_phys = '0; n_rd = 1'b0; n_wr = 1'b0;
    end
  end

  assign tlb_lookup = req_valid && want_map;
  assign tlb_vaddr  = req_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      phys_addr  <= '0;
      perm_read  <= 1'b0;
      perm_write <= 1'b0;
      fault      <= 1'b0;
      exc_code   <= '0;
      refill     <= 1'b0;
      bad_vaddr  <= '0;
      ctx_out    <= '0;
      ehi_out    <= '0;
    end else begin
      out_valid  <= req_valid;
      phys_addr  <= req_valid ? n_phys : '0;
      perm_read  <= req_valid && n_rd;
      perm_write <= req_valid && n_wr;
      fault      <= req_valid && n_fault;
      exc_code   <= req_valid ? n_code : '0;
      refill     <= req_valid && n_refill;
      if (req_valid && n_fault) begin
        bad_vaddr <= req_addr;
        ctx_out   <= {ctx_in[31:23], req_addr[31:13], 4'b0000};
        ehi_out   <= {req_addr[31:13], 5'b00000, ehi_in[7:0]};
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic [1:0]  req_mode,
  input logic        err_lvl,
  input logic        tlb_lookup,
  input logic [31:0] phys_addr,
  input logic        fault,
  input logic [4:0]  exc_code,
  input logic        refill,
  input logic [31:0] bad_vaddr
);
  p_bypass_nolookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_addr[31] && err_lvl) |-> !tlb_lookup);

  p_kseg0_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:29] == 3'b100 && req_mode == 2'd0) |=>
      (!fault && phys_addr[31:29] == 3'b000 && phys_addr[28:0] == $past(req_addr[28:0])));

  p_user_kernel_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31] && req_mode[1]) |=>
      (fault && (exc_code == 5'd4 || exc_code == 5'd5) && !refill));

  p_refill_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refill |-> (fault && (exc_code == 5'd2 || exc_code == 5'd3)));

  p_quiet_codes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (exc_code == 5'd0 && !refill));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(bad_vaddr));
endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_mode = '0;
  logic        err_lvl = 1'b0;
  logic [31:0] ctx_in = '0;
  logic [31:0] ehi_in = '0;
  logic        tlb_lookup;
  logic [31:0] tlb_vaddr;
  logic        tlb_hit = 1'b0, tlb_valid = 1'b0, tlb_dirty = 1'b0;
  logic [31:0] tlb_paddr = '0;
  logic        out_valid, perm_read, perm_write, fault, refill;
  logic [31:0] phys_addr, bad_vaddr, ctx_out, ehi_out;
  logic [4:0]  exc_code;

  int n_chk = 0, n_bad = 0;
  logic [31:0] e_bad = '0, e_ctx = '0, e_ehi = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate u_seg_xlate (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic one(input logic [31:0] a, input bit w, input logic [1:0] m,
                     input bit el, input bit h, input bit v, input bit d,
                     input logic [31:0] pa, input logic [31:0] ci, input logic [31:0] ei);
    bit kern, sup, map, bad, ef, er, rd, wr, lk;
    logic [4:0] ec;
    logic [31:0] ep;
    string tag;
    kern = (m == 2'd0); sup = (m == 2'd1);
    map = 0; bad = 0; ef = 0; er = 0; rd = 0; wr = 0; ec = 0; ep = 0; tag = "R2";
    if (!a[31]) begin
      if (el) begin ep = a; rd = 1; wr = 1; tag = "R2"; end else map = 1;
    end else if (a < 32'hA000_0000) begin
      if (kern) begin ep = a - 32'h8000_0000; rd = 1; wr = 1; tag = "R3"; end else bad = 1;
    end else if (a < 32'hC000_0000) begin
      if (kern) begin ep = a - 32'hA000_0000; rd = 1; wr = 1; tag = "R4"; end else bad = 1;
    end else if (a < 32'hE000_0000) begin
      if (kern || sup) map = 1; else bad = 1;
    end else begin
      if (kern) map = 1; else bad = 1;
    end
    lk = map;
    if (bad) begin ef = 1; ec = w ? 5'd5 : 5'd4; tag = "R6"; end
    else if (map) begin
      if (!h) begin ef = 1; er = 1; ec = w ? 5'd3 : 5'd2; tag = "R7"; end
      else if (!v) begin ef = 1; ec = w ? 5'd3 : 5'd2; tag = "R8"; end
      else if (w && !d) begin ef = 1; ec = 5'd1; tag = "R9"; end
      else begin ep = pa; rd = 1; wr = d; tag = d ? "R5" : "R9"; end
    end
    req_valid = 1; req_addr = a; req_write = w; req_mode = m; err_lvl = el;
    tlb_hit = h; tlb_valid = v; tlb_dirty = d; tlb_paddr = pa; ctx_in = ci; ehi_in = ei;
    #1;
    chk(tlb_lookup == lk && tlb_vaddr == a, "R5", "lookup", {31'b0, tlb_lookup}, {31'b0, lk});
    if (ef) begin
      e_bad = a;
      e_ctx = (ci & ~32'h007F_FFFF) | ((a >> 9) & 32'h007F_FFF0);
      e_ehi = (ei & 32'hFF) | (a & 32'hFFFF_E000);
    end
    @(posedge clk);
    @(negedge clk);
    chk(out_valid && fault == ef && exc_code == ec && refill == er, tag, "code",
        {25'b0, exc_code, fault, refill}, {25'b0, ec, ef, er});
    chk(phys_addr == ep && perm_read == rd && perm_write == wr, tag, "phys", phys_addr, ep);
    chk(bad_vaddr == e_bad && ctx_out == e_ctx && ehi_out == e_ehi,
        ef ? "R10" : "R11", "fregs", ctx_out ^ ehi_out ^ bad_vaddr, e_ctx ^ e_ehi ^ e_bad);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !fault && exc_code == 0 && phys_addr == 0 && bad_vaddr == 0 &&
        ctx_out == 0 && ehi_out == 0 && !perm_read && !perm_write && !refill,
        "R1", "reset", phys_addr | bad_vaddr, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !fault && bad_vaddr == 0, "R1", "post-reset", bad_vaddr, 32'h0);
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] a;
      a = {i[2:0], 29'(i * 32'h0123_4567 + 32'h0ACE_1357)};
      one(a, i[3], i[5:4], i[6], i[7], i[8], i[9],
          a ^ 32'h5A5A_3C3C, 32'hF0F0_0000 + i * 32'h1111, 32'hCC00_0000 | i);
    end
    one(32'hDEAD_B000, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0, 32'hFFFF_FFFF, 32'h0000_00A5);
    req_valid = 0; req_addr = 32'h8123_4000; req_mode = 2'd2; tlb_hit = 0;
    #1;
    chk(!tlb_lookup, "R11", "idle lookup", {31'b0, tlb_lookup}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk(!out_valid && !fault && exc_code == 0 && bad_vaddr == 32'hDEAD_B000 &&
        ehi_out == 32'hDEAD_A0A5, "R11", "idle hold", bad_vaddr, 32'hDEAD_B000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule